// File: doc/BRIEF.md
# Eight-Region Memory Protection Checker

The block holds a small set of programmable protection regions and judges every incoming access against them in the same cycle. For each access it reports whether the access is allowed or faults. When a region decides the access, it also reports that region's number and attributes. A region is a naturally aligned, power-of-two window with a base address, a size code, eight subregion-disable bits, an enable bit, an execute-never bit, an access-permission code and three memory-type flags. The memory-type flags are stored and reported but never change the verdict.

Software sets the block up through four word registers, chosen by a 2-bit select: a control word, a region-select word, a region base word and a region attribute word. A base write can also move the region select to another region in the same cycle. A global control word switches checking on or off. It also chooses whether checking stays on while high-priority fault handlers run, and whether privileged accesses that hit no region fall through to a default background map.

Top module: `mem_guard`

## Requirements
- R1: After reset every register reads 0. While control bit 0 (enable) is 0, every access gives fault_o=0 and hit_o=0.
- R2: Select 0 is control, with bit 0 enable, bit 1 check-during-high-priority and bit 2 privileged background. Select 1 is the region number in bits 2:0. Select 3 is the attribute word of the selected region: bit 0 enable, bits 5:1 SIZE, bits 15:8 subregion disables, bits 18:16 memory-type flags, bits 26:24 access code, bit 28 execute-never. All other bits read 0.
- R3: Select 2 holds the region base in bits 31:8. A write with bit 4 set first copies bits 2:0 into the region number, then writes that region's base. A write with bit 4 clear writes the base of the region already selected and leaves the region number unchanged. A read returns the base, returns 0 in bit 4, and returns the region number in bits 3:0.
- R4: A region covers 2^(SIZE+1) bytes, aligned to its size, so base bits below the size are ignored. A SIZE below 7 acts as 7 (256 bytes).
- R5: Subregion-disable bit k (attribute bit 8+k) removes the k-th eighth of the region, counted from its bottom. An access there is treated as missing that region.
- R6: When several enabled regions match, the highest-numbered one decides. hit_o=1 and hit_region_o, hit_xn_o, hit_ap_o and hit_scb_o report that region.
- R7: The access code in a matching region decides the verdict. 000 denies all. 001 allows privileged read and write only. 010 also allows unprivileged reads. 011 allows everything. 100 denies all. 101 allows privileged reads only. 110 and 111 allow reads for everyone.
- R8: An instruction fetch (acc_fetch_i=1) that hits a region with execute-never set faults.
- R9: With checking active and no region hit, a privileged access is allowed if control bit 2 is 1. Every other access faults, and hit_o=0.
- R10: With acc_hipri_i=1 and control bit 1 clear, every access is allowed and hit_o=0. With control bit 1 set, the same access is checked normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select (0 control, 1 region number, 2 base, 3 attributes) |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read data of the selected register |
| acc_addr_i | input | 32 | Access address |
| acc_priv_i | input | 1 | Access is privileged |
| acc_write_i | input | 1 | Access is a write |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| acc_hipri_i | input | 1 | Access issued from a high-priority fault handler |
| fault_o | output | 1 | Access faults |
| hit_o | output | 1 | A region decided the access |
| hit_region_o | output | 3 | Deciding region number |
| hit_xn_o | output | 1 | Execute-never of the deciding region |
| hit_ap_o | output | 3 | Access code of the deciding region |
| hit_scb_o | output | 3 | Memory-type flags of the deciding region |

## Verification
The assertions assume the access inputs are known and that a fetch is never flagged as a write. They also assume that a region-number write carries a value below the region count, so the VALID copy lands on a real region. The stimulus keeps acc_write_i low on every fetch and draws region numbers from 0 to 7. It mostly picks SIZE codes from 7 upward, with one directed case below 7 to show the clamp. Random region bases and addresses come from the same 1 MB window, so regions overlap, subregions get hit, and misses happen often.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RNUM = 2'd1,
    SEL_BASE = 2'd2,
    SEL_ATTR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [23:0] base;
    logic        en;
    logic [4:0]  size;
    logic [7:0]  srd;
    logic        xn;
    logic [2:0]  ap;
    logic [2:0]  scb;
  } region_t;

  function automatic logic ap_allows(logic [2:0] ap, logic priv, logic wr);
    case (ap)
      3'b001:         return priv;
      3'b010:         return priv | ~wr;
      3'b011:         return 1'b1;
      3'b101:         return priv & ~wr;
      3'b110, 3'b111: return ~wr;
      default:        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mem_guard_regs.sv
module mem_guard_regs
  import mem_guard_pkg::*;
#(
  parameter int NR = 8,
  localparam int RW = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic [2:0]    ctrl_o,
  output logic [RW-1:0] rnum_o,
  output region_t       rgn_o [NR]
);

  logic [2:0]    ctrl_q;
  logic [RW-1:0] rnum_q;
  logic [RW-1:0] tgt;
  region_t       rgn_q [NR];
  region_t       cur;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;
  // VALID retargets the region number in the same write
  assign tgt = (reg_sel_e'(sel_i) == SEL_BASE && wdata_i[4]) ? wdata_i[RW-1:0] : rnum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rnum_q <= '0;
      for (int i = 0; i < NR; i++) rgn_q[i] <= '0;
    end else if (we_i) begin
      case (reg_sel_e'(sel_i))
        SEL_CTRL: ctrl_q <= wdata_i[2:0];
        SEL_RNUM: rnum_q <= wdata_i[RW-1:0];
        SEL_BASE: begin
          rnum_q         <= tgt;
          rgn_q[tgt].base <= wdata_i[31:8];
        end
        SEL_ATTR: begin
          rgn_q[rnum_q].en   <= wdata_i[0];
          rgn_q[rnum_q].size <= wdata_i[5:1];
          rgn_q[rnum_q].srd  <= wdata_i[15:8];
          rgn_q[rnum_q].scb  <= wdata_i[18:16];
          rgn_q[rnum_q].ap   <= wdata_i[26:24];
          rgn_q[rnum_q].xn   <= wdata_i[28];
        end
        default: ;
      endcase
    end
  end

  assign cur = rgn_q[rnum_q];

  always_comb begin
    case (reg_sel_e'(sel_i))
      SEL_CTRL: rdata_o = {29'b0, ctrl_q};
      SEL_RNUM: rdata_o = {{(32-RW){1'b0}}, rnum_q};
      SEL_BASE: rdata_o = {cur.base, 4'b0, {(4-RW){1'b0}}, rnum_q};
      default:  rdata_o = {3'b0, cur.xn, 1'b0, cur.ap, 5'b0, cur.scb,
                           cur.srd, 2'b0, cur.size, cur.en};
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign rnum_o = rnum_q;
  assign rgn_o  = rgn_q;

endmodule

// File: rtl/mem_guard_match.sv
module mem_guard_match (
  input  logic [31:0] addr_i,
  input  logic [23:0] base_i,
  input  logic [4:0]  size_i,
  input  logic [7:0]  srd_i,
  input  logic        en_i,
  output logic        hit_o
);

  logic [4:0]  sz;
  logic [5:0]  sh;
  logic [32:0] span;
  logic [31:0] keep;
  logic [31:0] rel;
  logic [2:0]  sub;
  logic        unused_bits;

  always_comb begin
    sz   = (size_i < 5'd7) ? 5'd7 : size_i;
    sh   = {1'b0, sz} + 6'd1;
    span = (33'd1 << sh) - 33'd1;
    keep = ~span[31:0];
    // subregion index: top three offset bits inside the region
    rel  = addr_i >> (sz - 5'd2);
    sub  = rel[2:0];
    hit_o = en_i && ((addr_i & keep) == ({base_i, 8'h00} & keep)) && !srd_i[sub];
  end

  assign unused_bits = ^{span[32], rel[31:3]};

endmodule

// File: rtl/mem_guard_decide.sv
module mem_guard_decide
  import mem_guard_pkg::*;
#(
  parameter int NR = 8,
  localparam int RW = $clog2(NR)
) (
  input  logic [NR-1:0] hits_i,
  input  logic [2:0]    ap_i [NR],
  input  logic [2:0]    scb_i [NR],
  input  logic [NR-1:0] xn_i,
  input  logic [2:0]    ctrl_i,
  input  logic          priv_i,
  input  logic          write_i,
  input  logic          fetch_i,
  input  logic          hipri_i,
  output logic          fault_o,
  output logic          hit_o,
  output logic [RW-1:0] win_o,
  output logic          xn_o,
  output logic [2:0]    ap_o,
  output logic [2:0]    scb_o
);

  logic found;
  logic active;

  always_comb begin
    win_o = '0;
    found = 1'b0;
    for (int i = 0; i < NR; i++) begin
      if (hits_i[i]) begin
        win_o = RW'(i);
        found = 1'b1;
      end
    end
    xn_o  = xn_i[win_o];
    ap_o  = ap_i[win_o];
    scb_o = scb_i[win_o];
    active = ctrl_i[0] && !(hipri_i && !ctrl_i[1]);
    if (!active)    fault_o = 1'b0;
    else if (found) fault_o = !ap_allows(ap_o, priv_i, write_i) || (fetch_i && xn_o);
    else            fault_o = !(ctrl_i[2] && priv_i);
    hit_o = active && found;
  end

endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mem_guard_pkg::*;
#(
  parameter int NR = 8,
  localparam int RW = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic [31:0]   acc_addr_i,
  input  logic          acc_priv_i,
  input  logic          acc_write_i,
  input  logic          acc_fetch_i,
  input  logic          acc_hipri_i,
  output logic          fault_o,
  output logic          hit_o,
  output logic [RW-1:0] hit_region_o,
  output logic          hit_xn_o,
  output logic [2:0]    hit_ap_o,
  output logic [2:0]    hit_scb_o
);

  logic [2:0]    ctrl_w;
  logic [RW-1:0] rnum_w;
  region_t       rgn_w [NR];
  logic [NR-1:0] hits;
  logic [NR-1:0] xn_w;
  logic [2:0]    ap_w [NR];
  logic [2:0]    scb_w [NR];

  mem_guard_regs #(.NR(NR)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .ctrl_o  (ctrl_w),
    .rnum_o  (rnum_w),
    .rgn_o   (rgn_w)
  );

  for (genvar g = 0; g < NR; g++) begin : g_rgn
    mem_guard_match u_match (
      .addr_i (acc_addr_i),
      .base_i (rgn_w[g].base),
      .size_i (rgn_w[g].size),
      .srd_i  (rgn_w[g].srd),
      .en_i   (rgn_w[g].en),
      .hit_o  (hits[g])
    );
    assign xn_w[g]  = rgn_w[g].xn;
    assign ap_w[g]  = rgn_w[g].ap;
    assign scb_w[g] = rgn_w[g].scb;
  end

  mem_guard_decide #(.NR(NR)) u_decide (
    .hits_i  (hits),
    .ap_i    (ap_w),
    .scb_i   (scb_w),
    .xn_i    (xn_w),
    .ctrl_i  (ctrl_w),
    .priv_i  (acc_priv_i),
    .write_i (acc_write_i),
    .fetch_i (acc_fetch_i),
    .hipri_i (acc_hipri_i),
    .fault_o (fault_o),
    .hit_o   (hit_o),
    .win_o   (hit_region_o),
    .xn_o    (hit_xn_o),
    .ap_o    (hit_ap_o),
    .scb_o   (hit_scb_o)
  );

endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int NR = 8,
  localparam int RW = $clog2(NR)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    ctrl_i,
  input logic [RW-1:0] rnum_i,
  input logic          we_i,
  input logic [1:0]    sel_i,
  input logic          wvalid_i,
  input logic [RW-1:0] wnum_i,
  input logic          rvalid_i,
  input logic          priv_i,
  input logic          fetch_i,
  input logic          hipri_i,
  input logic          fault_i,
  input logic          hit_i,
  input logic          xn_i,
  input logic [2:0]    ap_i
);

  // R1
  off_allows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[0] |-> (!fault_i && !hit_i));

  // R10
  hipri_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && !ctrl_i[1] && hipri_i) |-> (!fault_i && !hit_i));

  // R8
  xn_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && xn_i && fetch_i) |-> fault_i);

  // R7
  ap_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && (ap_i == 3'b000 || ap_i == 3'b100)) |-> fault_i);

  // R9
  no_bg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && !(hipri_i && !ctrl_i[1]) && !hit_i && !(ctrl_i[2] && priv_i)) |-> fault_i);

  // R3
  retarget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd2 && wvalid_i) |=> (rnum_i == $past(wnum_i)));

  // R3
  valid_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd2) |-> !rvalid_i);

endmodule

bind mem_guard mem_guard_chk #(.NR(NR)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctrl_i   (ctrl_w),
  .rnum_i   (rnum_w),
  .we_i     (cfg_we_i),
  .sel_i    (cfg_sel_i),
  .wvalid_i (cfg_wdata_i[4]),
  .wnum_i   (cfg_wdata_i[RW-1:0]),
  .rvalid_i (cfg_rdata_o[4]),
  .priv_i   (acc_priv_i),
  .fetch_i  (acc_fetch_i),
  .hipri_i  (acc_hipri_i),
  .fault_i  (fault_o),
  .hit_i    (hit_o),
  .xn_i     (hit_xn_o),
  .ap_i     (hit_ap_o)
);

// File: tb/sim_mem_guard.sv
module sim_mem_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] acc_addr = '0;
  logic        acc_priv = 1'b0, acc_write = 1'b0, acc_fetch = 1'b0, acc_hipri = 1'b0;
  logic        fault, hit, hxn;
  logic [2:0]  hreg, hap, hscb;

  int tests = 0;
  int fails = 0;

  logic [23:0] sh_base [8];
  logic [4:0]  sh_size [8];
  logic [7:0]  sh_srd  [8];
  logic [2:0]  sh_ap   [8];
  logic [2:0]  sh_scb  [8];
  logic        sh_xn   [8];
  logic        sh_en   [8];
  logic [2:0]  sh_ctrl = '0;

  always #10ns clk = ~clk;

  mem_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .acc_addr_i(acc_addr),
    .acc_priv_i(acc_priv), .acc_write_i(acc_write), .acc_fetch_i(acc_fetch),
    .acc_hipri_i(acc_hipri), .fault_o(fault), .hit_o(hit), .hit_region_o(hreg),
    .hit_xn_o(hxn), .hit_ap_o(hap), .hit_scb_o(hscb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit perm_ok(input logic [2:0] ap, input bit pv, input bit wr);
    bit r;
    case (ap)
      3'd0, 3'd4: r = 0;
      3'd1: r = pv;
      3'd2: r = wr ? pv : 1'b1;
      3'd3: r = 1;
      3'd5: r = pv && !wr;
      default: r = !wr;
    endcase
    return r;
  endfunction

  function automatic void model(input logic [31:0] a, input bit pv, input bit wr,
                                input bit fx, input bit hp,
                                output bit f, output bit h, output int w);
    bit act;
    h = 0; w = 0;
    for (int i = 0; i < 8; i++) begin
      int s;
      longint unsigned bytes, st, off;
      s = (sh_size[i] < 5'd7) ? 7 : int'(sh_size[i]);
      bytes = 64'd1 << (s + 1);
      st = {32'h0, sh_base[i], 8'h00};
      st = st - (st % bytes);
      off = {32'h0, a} - st;
      if (sh_en[i] && {32'h0, a} >= st && {32'h0, a} < st + bytes)
        if (!sh_srd[i][off / (bytes / 8)]) begin h = 1; w = i; end
    end
    act = sh_ctrl[0] && !(hp && !sh_ctrl[1]);
    if (!act) begin f = 0; h = 0; end
    else if (h) f = !perm_ok(sh_ap[w], pv, wr) || (fx && sh_xn[w]);
    else f = !(sh_ctrl[2] && pv);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #2ns d = cfg_rdata;
  endtask

  task automatic set_ctrl(input logic [2:0] c);
    wr(2'd0, {29'b0, c});
    sh_ctrl = c;
  endtask

  task automatic set_region(input int idx, input logic [23:0] base, input logic [4:0] size,
                            input logic [7:0] srd, input logic [2:0] ap, input bit xn,
                            input bit en, input logic [2:0] scb);
    wr(2'd2, {base, 3'b000, 1'b1, 4'(idx)});
    wr(2'd3, {3'b0, xn, 1'b0, ap, 5'b0, scb, srd, 2'b0, size, en});
    sh_base[idx] = base; sh_size[idx] = size; sh_srd[idx] = srd;
    sh_ap[idx] = ap; sh_xn[idx] = xn; sh_en[idx] = en; sh_scb[idx] = scb;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 8; i++) set_region(i, '0, 5'd0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic probe(input string req, input logic [31:0] a, input bit pv, input bit w,
                       input bit fx, input bit hp);
    bit ef, eh;
    int ew;
    @(negedge clk);
    acc_addr = a; acc_priv = pv; acc_write = w; acc_fetch = fx; acc_hipri = hp;
    #2ns;
    model(a, pv, w, fx, hp, ef, eh, ew);
    check({req, " fault"}, {31'b0, fault}, {31'b0, ef});
    check({req, " hit"}, {31'b0, hit}, {31'b0, eh});
    if (eh) begin
      check({req, " region"}, {29'b0, hreg}, 32'(ew));
      check({req, " attrs"}, {25'b0, hxn, hap, hscb}, {25'b0, sh_xn[ew], sh_ap[ew], sh_scb[ew]});
    end
  endtask

  bit finished = 0;

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin
      sh_base[i] = '0; sh_size[i] = '0; sh_srd[i] = '0; sh_ap[i] = '0;
      sh_xn[i] = 0; sh_en[i] = 0; sh_scb[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      check("R1 reset read", d, 32'h0);
    end
    probe("R1 disabled", 32'h1234_5678, 0, 1, 0, 0);
    check("R1 literal", {30'b0, fault, hit}, 32'h0);

    // R2 register map
    set_ctrl(3'b101);
    rd(2'd0, d); check("R2 ctrl", d, 32'h5);
    wr(2'd0, 32'hFFFF_FFF8); sh_ctrl = 3'b000;
    rd(2'd0, d); check("R2 ctrl mask", d, 32'h0);
    wr(2'd1, 32'd5);
    rd(2'd1, d); check("R2 rnum", d, 32'd5);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); check("R2 attr mask", d, 32'h1707_FF3F);

    // R3 VALID retarget and plain base write
    wr(2'd2, 32'hABCD_EF16);
    rd(2'd1, d); check("R3 retarget rnum", d, 32'd6);
    rd(2'd2, d); check("R3 base readback", d, 32'hABCD_EF06);
    wr(2'd2, 32'h1111_2202);
    rd(2'd1, d); check("R3 rnum kept", d, 32'd6);
    rd(2'd2, d); check("R3 base update", d, 32'h1111_2206);
    wr(2'd1, 32'd5);
    rd(2'd3, d); check("R3 other region untouched", d, 32'h1707_FF3F);
    clear_all();

    // R4 size and alignment
    set_ctrl(3'b001);
    set_region(0, 24'h000013, 5'd11, 8'h00, 3'b011, 0, 1, 3'b010);
    probe("R4 low edge", 32'h0000_1000, 0, 0, 0, 0);
    check("R4 low edge literal", {31'b0, hit}, 32'h1);
    probe("R4 high edge", 32'h0000_1FFF, 0, 1, 0, 0);
    probe("R4 beyond", 32'h0000_2000, 0, 0, 0, 0);
    check("R4 beyond literal", {30'b0, fault, hit}, 32'h2);
    set_region(1, 24'h000040, 5'd3, 8'h00, 3'b011, 0, 1, 3'b000);
    probe("R4 clamp in", 32'h0000_40FF, 0, 0, 0, 0);
    probe("R4 clamp out", 32'h0000_4100, 0, 0, 0, 0);

    // R5 subregions
    set_region(0, 24'h000010, 5'd11, 8'h04, 3'b011, 0, 1, 3'b001);
    probe("R5 disabled sub", 32'h0000_1400, 0, 0, 0, 0);
    check("R5 literal", {30'b0, fault, hit}, 32'h2);
    probe("R5 enabled sub", 32'h0000_1600, 0, 0, 0, 0);

    // R6 overlap priority
    set_region(5, 24'h000010, 5'd9, 8'h00, 3'b110, 1, 1, 3'b111);
    probe("R6 overlap", 32'h0000_1010, 1, 0, 0, 0);
    check("R6 winner literal", {29'b0, hreg}, 32'd5);
    probe("R6 lower only", 32'h0000_1810, 1, 1, 0, 0);
    set_region(5, '0, 5'd0, '0, '0, 0, 0, '0);
    set_region(1, '0, 5'd0, '0, '0, 0, 0, '0);

    // R7 access codes
    for (int ap = 0; ap < 8; ap++) begin
      set_region(0, 24'h000010, 5'd11, 8'h00, 3'(ap), 0, 1, 3'b000);
      for (int m = 0; m < 4; m++) probe("R7 ap", 32'h0000_1100, m[1], m[0], 0, 0);
    end

    // R8 execute-never
    set_region(0, 24'h000010, 5'd11, 8'h00, 3'b011, 1, 1, 3'b000);
    probe("R8 xn fetch", 32'h0000_1200, 1, 0, 1, 0);
    check("R8 literal", {31'b0, fault}, 32'h1);
    probe("R8 xn read", 32'h0000_1200, 1, 0, 0, 0);

    // R9 background
    probe("R9 miss no bg", 32'h0008_0000, 1, 0, 0, 0);
    set_ctrl(3'b101);
    probe("R9 miss bg priv", 32'h0008_0000, 1, 1, 0, 0);
    check("R9 literal", {30'b0, fault, hit}, 32'h0);
    probe("R9 miss bg unpriv", 32'h0008_0000, 0, 0, 0, 0);

    // R10 high-priority bypass
    set_ctrl(3'b001);
    probe("R10 bypass", 32'h0008_0000, 0, 1, 0, 1);
    check("R10 literal", {30'b0, fault, hit}, 32'h0);
    set_ctrl(3'b011);
    probe("R10 kept on", 32'h0008_0000, 0, 1, 0, 1);

    // random rounds
    for (int r = 0; r < 25; r++) begin
      for (int i = 0; i < 8; i++) begin
        logic [4:0] sz;
        sz = ($urandom % 8 == 0) ? 5'(7 + $urandom % 25) : 5'(7 + $urandom % 12);
        set_region(i, 24'($urandom & 32'h0000_0FFF), sz, 8'($urandom % 4 == 0 ? $urandom : 0),
                   3'($urandom), 1'($urandom), ($urandom % 5) != 0, 3'($urandom));
      end
      set_ctrl(3'($urandom));
      for (int k = 0; k < 60; k++) begin
        bit fx;
        fx = ($urandom % 4) == 0;
        probe("R6 R7 random", $urandom & 32'h000F_FFFF, 1'($urandom), fx ? 1'b0 : 1'($urandom),
              fx, ($urandom % 6) == 0);
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule